// File: doc/BRIEF.md
# Lockable Translation Lookaside Buffer

This block is a small, fully associative address-translation cache. Every entry has a match half and a data half. The match half holds a valid flag, a keep flag, a page-size code and a virtual page number. The data half holds a physical page number and an access-permission code. A lookup compares the request against all entries at once. On a hit it returns the translated physical address and the permission in the same cycle.

Entries are written either by a table-walk result or by a register write. The block does not care which source drives the load port. A lock register holds a floor index and a victim pointer. Each load goes to the victim slot, and slots under the floor are never chosen. Software can clear all entries that lack the keep flag, or clear only the entries that cover one page. It can also read back any slot by its index.

Top module: `lock_tlb`

## Requirements
- R1: After reset every slot is invalid with all fields zero, the lock floor and the victim pointer are both 0, and no lookup hits.
- R2: A slot matches when it is valid and the virtual address agrees with its page number on bits [31:20] for size code 0 (1 MB section), [31:16] for code 1 (64 KB), [31:12] for code 2 (4 KB) or [31:10] for code 3 (1 KB). A hit is reported in the same cycle as `lk_req`. With `lk_req` low, or on a miss, `lk_hit`, `lk_paddr` and `lk_perm` are all 0.
- R3: On a hit, `lk_paddr` takes its upper bits from the slot's physical page number and its page-offset bits (20, 16, 12 or 10 of them, by size) from the virtual address. `lk_perm` gives the slot's permission code: 0 no access, 1 read-only, 2 full access.
- R4: When several slots match, the slot with the lowest index supplies the result.
- R5: A load writes page number, size, permission and keep flag into the slot at the victim pointer and marks it valid. Lookup and readback show the new content from the next cycle.
- R6: Each load moves the victim pointer up by one. A load at the last slot sends the pointer back to the lock floor.
- R7: A lock write sets the floor and victim fields. If the written victim is below the written floor, the victim becomes the floor. Slots under the floor are never overwritten by loads.
- R8: A flush-all clears the valid flag of every slot whose keep flag is 0 and leaves kept slots valid.
- R9: A single-page flush clears the valid flag of every slot that matches the given page under R2 rules, whatever its keep flag, and leaves other slots unchanged.
- R10: Readback presents the valid flag, keep flag, size, permission, virtual page and physical page of the slot chosen by `rd_idx`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | PA_W | Translated physical address |
| lk_perm | output | 2 | Permission code of the hit |
| ld_en | input | 1 | Load a slot at the victim pointer |
| ld_vpn | input | VA_W-10 | Virtual page number, address bits [VA_W-1:10] |
| ld_size | input | 2 | Page-size code to load |
| ld_perm | input | 2 | Permission code to load |
| ld_keep | input | 1 | Keep flag (survives flush-all) |
| ld_ppn | input | PA_W-10 | Physical page number, address bits [PA_W-1:10] |
| lock_wr | input | 1 | Write the lock register |
| lock_base_in | input | log2(ENTRIES) | Lock floor to write |
| lock_victim_in | input | log2(ENTRIES) | Victim pointer to write |
| lock_base | output | log2(ENTRIES) | Current lock floor |
| lock_victim | output | log2(ENTRIES) | Current victim pointer |
| flush_all | input | 1 | Clear all slots without the keep flag |
| flush_one | input | 1 | Clear slots matching `flush_vpn` |
| flush_vpn | input | VA_W-10 | Page to flush, address bits [VA_W-1:10] |
| rd_idx | input | log2(ENTRIES) | Slot index to read back |
| rd_valid | output | 1 | Valid flag of the read slot |
| rd_keep | output | 1 | Keep flag of the read slot |
| rd_size | output | 2 | Size code of the read slot |
| rd_perm | output | 2 | Permission code of the read slot |
| rd_vtag | output | VA_W-10 | Virtual page number of the read slot |
| rd_pbase | output | PA_W-10 | Physical page number of the read slot |

## Verification
Lookup results and readback values are combinational. They are due in the same cycle the request is presented. Loads, flushes and lock writes take effect at the next rising edge, so their effects appear one cycle after the stimulus. The driver changes inputs on the falling edge and queues what it expects. The monitor compares 2 ns later, still before the next rising edge, so each check sees exactly the state left by the previous edge.

// File: rtl/lock_tlb_pkg.sv
package lock_tlb_pkg;

   // Page-size codes stored per slot; the match width depends on them.
   typedef enum logic [1:0] {
      PG_SECTION = 2'd0,   // 1 MB
      PG_LARGE   = 2'd1,   // 64 KB
      PG_SMALL   = 2'd2,   // 4 KB
      PG_TINY    = 2'd3    // 1 KB
   } pg_size_e;

   // Finest page granule in address bits.
   localparam int unsigned GRAIN_BITS = 10;

endpackage

// File: rtl/lock_tlb_match.sv
module lock_tlb_match
   import lock_tlb_pkg::*;
#(
   parameter int unsigned VA_W = 32
) (
   input  logic                       vld,
   input  logic [1:0]                 size,
   input  logic [VA_W-GRAIN_BITS-1:0] tag,
   input  logic [VA_W-GRAIN_BITS-1:0] probe,
   output logic                       hit
);
   localparam int unsigned TW = VA_W - GRAIN_BITS;

   logic [TW-1:0] care;

   // Ignore the page-number bits that fall inside the page offset.
   always_comb begin
      case (size)
         PG_SECTION: care = {TW{1'b1}} << 10;
         PG_LARGE:   care = {TW{1'b1}} << 6;
         PG_SMALL:   care = {TW{1'b1}} << 2;
         default:    care = {TW{1'b1}};
      endcase
   end

   assign hit = vld && (((probe ^ tag) & care) == '0);

endmodule

// File: rtl/lock_tlb_pick.sv
module lock_tlb_pick #(
   parameter int unsigned N     = 32,
   parameter int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   // Isolate the lowest set bit.
   assign grant = req & (~req + {{(N-1){1'b0}}, 1'b1});
   assign any   = |req;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | IDX_W'(i);
      end
   end

endmodule

// File: rtl/lock_tlb_victim.sv
module lock_tlb_victim #(
   parameter int unsigned N     = 32,
   parameter int unsigned IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] wr_base,
   input  logic [IDX_W-1:0] wr_victim,
   input  logic             adv,
   output logic [IDX_W-1:0] base,
   output logic [IDX_W-1:0] victim
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base   <= '0;
         victim <= '0;
      end else if (wr) begin
         base   <= wr_base;
         victim <= (wr_victim < wr_base) ? wr_base : wr_victim;
      end else if (adv) begin
         victim <= (victim == LAST) ? base : victim + IDX_W'(1);
      end
   end

   a_r7_victim_floor: assert property (@(posedge clk) disable iff (!rst_n)
      victim >= base);

   a_r7_lock_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> base == $past(wr_base));

   a_r6_advance_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !wr && victim != LAST) |=> victim == $past(victim) + IDX_W'(1));

   a_r6_advance_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !wr && victim == LAST) |=> victim == $past(base));

endmodule

// File: rtl/lock_tlb.sv
module lock_tlb
   import lock_tlb_pkg::*;
#(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned VA_W    = 32,
   parameter int unsigned PA_W    = 32,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned TW     = VA_W - GRAIN_BITS,
   localparam int unsigned PW     = PA_W - GRAIN_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_req,
   input  logic [VA_W-1:0]  lk_vaddr,
   output logic             lk_hit,
   output logic [PA_W-1:0]  lk_paddr,
   output logic [1:0]       lk_perm,
   input  logic             ld_en,
   input  logic [TW-1:0]    ld_vpn,
   input  logic [1:0]       ld_size,
   input  logic [1:0]       ld_perm,
   input  logic             ld_keep,
   input  logic [PW-1:0]    ld_ppn,
   input  logic             lock_wr,
   input  logic [IDX_W-1:0] lock_base_in,
   input  logic [IDX_W-1:0] lock_victim_in,
   output logic [IDX_W-1:0] lock_base,
   output logic [IDX_W-1:0] lock_victim,
   input  logic             flush_all,
   input  logic             flush_one,
   input  logic [TW-1:0]    flush_vpn,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic             rd_keep,
   output logic [1:0]       rd_size,
   output logic [1:0]       rd_perm,
   output logic [TW-1:0]    rd_vtag,
   output logic [PW-1:0]    rd_pbase
);

   // Elaboration-time parameter checks
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("lock_tlb: ENTRIES must be a power of two, at least 2");
   end
   if (VA_W < 21 || VA_W > 64) begin : g_bad_va
      $error("lock_tlb: VA_W must lie in 21..64");
   end
   if (PA_W < 21 || PA_W > 64) begin : g_bad_pa
      $error("lock_tlb: PA_W must lie in 21..64");
   end

   // Slot state, flattened for selection
   logic [ENTRIES-1:0] vld_v;
   logic [ENTRIES-1:0] keep_v;
   logic [ENTRIES-1:0] lk_match_v;
   logic [ENTRIES-1:0] sf_match_v;
   logic [1:0]         size_a [ENTRIES];
   logic [1:0]         perm_a [ENTRIES];
   logic [TW-1:0]      tag_a  [ENTRIES];
   logic [PW-1:0]      pb_a   [ENTRIES];

   // Replacement control
   lock_tlb_victim #(
      .N     (ENTRIES),
      .IDX_W (IDX_W)
   ) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (lock_wr),
      .wr_base   (lock_base_in),
      .wr_victim (lock_victim_in),
      .adv       (ld_en),
      .base      (lock_base),
      .victim    (lock_victim)
   );

   // One storage slot and two comparators per entry
   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic          vld_q;
      logic          keep_q;
      logic [1:0]    size_q;
      logic [1:0]    perm_q;
      logic [TW-1:0] tag_q;
      logic [PW-1:0] pb_q;
      logic          load_here;

      assign load_here = ld_en && (lock_victim == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            keep_q <= 1'b0;
            size_q <= '0;
            perm_q <= '0;
            tag_q  <= '0;
            pb_q   <= '0;
         end else if (load_here) begin
            vld_q  <= 1'b1;
            keep_q <= ld_keep;
            size_q <= ld_size;
            perm_q <= ld_perm;
            tag_q  <= ld_vpn;
            pb_q   <= ld_ppn;
         end else if ((flush_all && !keep_q) || (flush_one && sf_match_v[i])) begin
            vld_q  <= 1'b0;
         end
      end

      lock_tlb_match #(.VA_W(VA_W)) u_lk_cmp (
         .vld   (vld_q),
         .size  (size_q),
         .tag   (tag_q),
         .probe (lk_vaddr[VA_W-1:GRAIN_BITS]),
         .hit   (lk_match_v[i])
      );

      lock_tlb_match #(.VA_W(VA_W)) u_sf_cmp (
         .vld   (vld_q),
         .size  (size_q),
         .tag   (tag_q),
         .probe (flush_vpn),
         .hit   (sf_match_v[i])
      );

      assign vld_v[i]  = vld_q;
      assign keep_v[i] = keep_q;
      assign size_a[i] = size_q;
      assign perm_a[i] = perm_q;
      assign tag_a[i]  = tag_q;
      assign pb_a[i]   = pb_q;
   end

   // Lowest-index winner among matching slots
   logic [ENTRIES-1:0] lk_grant;
   logic               lk_any;
   logic [IDX_W-1:0]   lk_sel;

   lock_tlb_pick #(
      .N     (ENTRIES),
      .IDX_W (IDX_W)
   ) u_pick (
      .req   (lk_match_v & {ENTRIES{lk_req}}),
      .grant (lk_grant),
      .any   (lk_any),
      .idx   (lk_sel)
   );

   function automatic logic [PA_W-1:0] join_pa(input logic [1:0]      sz,
                                               input logic [PW-1:0]   pb,
                                               input logic [VA_W-1:0] va);
      case (sz)
         PG_SECTION: return {pb[PW-1:10], va[19:0]};
         PG_LARGE:   return {pb[PW-1:6],  va[15:0]};
         PG_SMALL:   return {pb[PW-1:2],  va[11:0]};
         default:    return {pb,          va[GRAIN_BITS-1:0]};
      endcase
   endfunction

   assign lk_hit   = lk_any;
   assign lk_paddr = lk_any ? join_pa(size_a[lk_sel], pb_a[lk_sel], lk_vaddr) : '0;
   assign lk_perm  = lk_any ? perm_a[lk_sel] : 2'd0;

   // Readback port
   assign rd_valid = vld_v[rd_idx];
   assign rd_keep  = keep_v[rd_idx];
   assign rd_size  = size_a[rd_idx];
   assign rd_perm  = perm_a[rd_idx];
   assign rd_vtag  = tag_a[rd_idx];
   assign rd_pbase = pb_a[rd_idx];

   // Checks on the assembled behaviour
   a_r2_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_req);

   a_r4_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_grant) && (lk_any == (lk_grant != '0)));

   a_r5_load_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> vld_v[$past(lock_victim)]);

   a_r8_flush_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_all && !ld_en) |=> (vld_v & ~keep_v) == '0);

   a_r9_flush_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_one && !ld_en) |=> (vld_v & $past(sf_match_v)) == '0);

endmodule

// File: tb/lock_tlb_tb.sv
module lock_tlb_tb;

   localparam int K_LOOK = 0;
   localparam int K_RD   = 1;
   localparam int K_LOCK = 2;

   typedef struct {
      int          kind;
      string       req;
      logic [63:0] exp;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done   = 0;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        lk_req = 0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_hit;
   logic [31:0] lk_paddr;
   logic [1:0]  lk_perm;
   logic        ld_en = 0;
   logic [21:0] ld_vpn = '0;
   logic [1:0]  ld_size = '0;
   logic [1:0]  ld_perm = '0;
   logic        ld_keep = 0;
   logic [21:0] ld_ppn = '0;
   logic        lock_wr = 0;
   logic [4:0]  lock_base_in = '0;
   logic [4:0]  lock_victim_in = '0;
   logic [4:0]  lock_base;
   logic [4:0]  lock_victim;
   logic        flush_all = 0;
   logic        flush_one = 0;
   logic [21:0] flush_vpn = '0;
   logic [4:0]  rd_idx = '0;
   logic        rd_valid;
   logic        rd_keep;
   logic [1:0]  rd_size;
   logic [1:0]  rd_perm;
   logic [21:0] rd_vtag;
   logic [21:0] rd_pbase;

   always #4 clk = ~clk;   // 125 MHz

   lock_tlb u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
      .lk_paddr(lk_paddr), .lk_perm(lk_perm),
      .ld_en(ld_en), .ld_vpn(ld_vpn), .ld_size(ld_size), .ld_perm(ld_perm),
      .ld_keep(ld_keep), .ld_ppn(ld_ppn),
      .lock_wr(lock_wr), .lock_base_in(lock_base_in),
      .lock_victim_in(lock_victim_in), .lock_base(lock_base),
      .lock_victim(lock_victim),
      .flush_all(flush_all), .flush_one(flush_one), .flush_vpn(flush_vpn),
      .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_keep(rd_keep),
      .rd_size(rd_size), .rd_perm(rd_perm), .rd_vtag(rd_vtag),
      .rd_pbase(rd_pbase)
   );

   // Monitor: compares queued expectations before the next rising edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (q.size() > 0) begin
            item_t       it;
            logic [63:0] act;
            it = q.pop_front();
            case (it.kind)
               K_LOOK:  act = {29'b0, lk_hit, lk_perm, lk_paddr};
               K_RD:    act = {14'b0, rd_valid, rd_keep, rd_size, rd_perm, rd_vtag, rd_pbase};
               default: act = {54'b0, lock_base, lock_victim};
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // Driver tasks
   task automatic do_load(input logic [31:0] va, input logic [1:0] sz,
                          input logic [1:0] pm, input logic kp, input logic [31:0] pa);
      @(negedge clk);
      ld_en = 1; ld_vpn = va[31:10]; ld_size = sz; ld_perm = pm;
      ld_keep = kp; ld_ppn = pa[31:10];
      @(negedge clk);
      ld_en = 0;
   endtask

   task automatic exp_look(input string rq, input logic rqv, input logic [31:0] va,
                           input logic eh, input logic [31:0] epa, input logic [1:0] epm);
      item_t it;
      @(negedge clk);
      lk_req = rqv; lk_vaddr = va;
      it.kind = K_LOOK; it.req = rq;
      it.exp  = {29'b0, eh, eh ? epm : 2'd0, eh ? epa : 32'd0};
      q.push_back(it);
   endtask

   task automatic exp_rd(input string rq, input int idx, input logic ev, input logic ek,
                         input logic [1:0] es, input logic [1:0] ep,
                         input logic [31:0] va, input logic [31:0] pa);
      item_t it;
      @(negedge clk);
      rd_idx = 5'(idx);
      it.kind = K_RD; it.req = rq;
      it.exp  = {14'b0, ev, ek, es, ep, va[31:10], pa[31:10]};
      q.push_back(it);
   endtask

   task automatic exp_lock(input string rq, input int b, input int v);
      item_t it;
      @(negedge clk);
      it.kind = K_LOCK; it.req = rq;
      it.exp  = {54'b0, 5'(b), 5'(v)};
      q.push_back(it);
   endtask

   task automatic do_lock(input int b, input int v);
      @(negedge clk);
      lock_wr = 1; lock_base_in = 5'(b); lock_victim_in = 5'(v);
      @(negedge clk);
      lock_wr = 0;
   endtask

   task automatic do_flush_all();
      @(negedge clk);
      flush_all = 1;
      @(negedge clk);
      flush_all = 0;
   endtask

   task automatic do_flush_one(input logic [31:0] va);
      @(negedge clk);
      flush_one = 1; flush_vpn = va[31:10];
      @(negedge clk);
      flush_one = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      exp_lock("R1 lock reset", 0, 0);
      exp_look("R1 no hit after reset", 1, 32'h1234_5678, 0, 0, 0);
      exp_rd("R1 slot0 cleared", 0, 0, 0, 0, 0, 0, 0);
      exp_rd("R1 slot31 cleared", 31, 0, 0, 0, 0, 0, 0);

      // R5 loads of each page size
      do_load(32'h1234_5678, 2'd0, 2'd2, 0, 32'h4560_0000);
      do_load(32'hABCD_0000, 2'd1, 2'd1, 0, 32'h1111_0000);
      do_load(32'h0004_2000, 2'd2, 2'd0, 1, 32'h9876_5000);
      do_load(32'h7FFF_FC00, 2'd3, 2'd2, 0, 32'h0000_0400);
      exp_rd("R5 slot2 content", 2, 1, 1, 2'd2, 2'd0, 32'h0004_2000, 32'h9876_5000);
      exp_rd("R10 slot0 content", 0, 1, 0, 2'd0, 2'd2, 32'h1234_5678, 32'h4560_0000);

      // R2/R3 match width and address assembly
      exp_look("R2 section hit", 1, 32'h1234_5678, 1, 32'h4564_5678, 2'd2);
      exp_look("R2 section top", 1, 32'h123F_FFFF, 1, 32'h456F_FFFF, 2'd2);
      exp_look("R2 section miss", 1, 32'h1240_0000, 0, 0, 0);
      exp_look("R2 no req no hit", 0, 32'h1234_5678, 0, 0, 0);
      exp_look("R3 large hit", 1, 32'hABCD_1234, 1, 32'h1111_1234, 2'd1);
      exp_look("R2 large miss", 1, 32'hABCE_0000, 0, 0, 0);
      exp_look("R3 small hit no-access", 1, 32'h0004_2ABC, 1, 32'h9876_5ABC, 2'd0);
      exp_look("R2 small miss", 1, 32'h0004_3000, 0, 0, 0);
      exp_look("R3 tiny hit", 1, 32'h7FFF_FDEF, 1, 32'h0000_05EF, 2'd2);
      exp_look("R2 tiny miss", 1, 32'h7FFF_F800, 0, 0, 0);
      exp_lock("R6 victim after four loads", 0, 4);

      // R4 overlapping entries
      do_load(32'hABC0_0000, 2'd0, 2'd1, 0, 32'h2000_0000);
      exp_look("R4 lowest index wins", 1, 32'hABCD_1234, 1, 32'h1111_1234, 2'd1);
      exp_look("R4 single match on slot4", 1, 32'hABC0_1234, 1, 32'h2000_1234, 2'd1);
      exp_lock("R6 victim step", 0, 5);

      // R7 lock writes
      do_lock(2, 6);
      exp_lock("R7 lock plain write", 2, 6);
      do_lock(3, 1);
      exp_lock("R7 victim raised to floor", 3, 3);
      do_load(32'h0000_1000, 2'd3, 2'd2, 0, 32'h0000_2000);
      exp_rd("R5 load at victim slot3", 3, 1, 0, 2'd3, 2'd2, 32'h0000_1000, 32'h0000_2000);
      exp_rd("R7 slot2 untouched", 2, 1, 1, 2'd2, 2'd0, 32'h0004_2000, 32'h9876_5000);
      exp_look("R5 old slot3 gone", 1, 32'h7FFF_FDEF, 0, 0, 0);
      exp_lock("R6 victim after load", 3, 4);

      // R6 wrap to floor
      for (int i = 4; i < 32; i++) begin
         do_load(32'h1000_0000 + (i << 12), 2'd2, 2'd2, 0, 32'h3000_0000 + (i << 12));
      end
      exp_lock("R6 wrap to floor", 3, 3);
      exp_look("R5 last slot hit", 1, 32'h1001_F123, 1, 32'h3001_F123, 2'd2);
      exp_rd("R10 slot4 content", 4, 1, 0, 2'd2, 2'd2, 32'h1000_4000, 32'h3000_4000);
      do_load(32'h0ABC_D000, 2'd2, 2'd1, 0, 32'h0DEA_D000);
      exp_rd("R6 wrapped load at slot3", 3, 1, 0, 2'd2, 2'd1, 32'h0ABC_D000, 32'h0DEA_D000);
      exp_rd("R7 slot0 kept", 0, 1, 0, 2'd0, 2'd2, 32'h1234_5678, 32'h4560_0000);
      exp_rd("R7 slot1 kept", 1, 1, 0, 2'd1, 2'd1, 32'hABCD_0000, 32'h1111_0000);
      exp_lock("R6 victim after wrap load", 3, 4);

      // R8 flush all
      do_flush_all();
      exp_rd("R8 slot0 cleared", 0, 0, 0, 2'd0, 2'd2, 32'h1234_5678, 32'h4560_0000);
      exp_rd("R8 kept slot2 valid", 2, 1, 1, 2'd2, 2'd0, 32'h0004_2000, 32'h9876_5000);
      exp_look("R8 kept slot hits", 1, 32'h0004_2ABC, 1, 32'h9876_5ABC, 2'd0);
      exp_look("R8 flushed section misses", 1, 32'h1234_5678, 0, 0, 0);
      exp_look("R8 flushed small misses", 1, 32'h1001_F123, 0, 0, 0);

      // R9 single-page flush
      do_load(32'h5555_5000, 2'd2, 2'd2, 0, 32'h6666_6000);
      do_load(32'h7777_7000, 2'd2, 2'd1, 0, 32'h8888_8000);
      exp_lock("R6 victim after two loads", 3, 6);
      do_flush_one(32'h5555_5ABC);
      exp_look("R9 flushed page misses", 1, 32'h5555_5ABC, 0, 0, 0);
      exp_look("R9 other page still hits", 1, 32'h7777_7004, 1, 32'h8888_8004, 2'd1);
      exp_rd("R9 slot4 invalid", 4, 0, 0, 2'd2, 2'd2, 32'h5555_5000, 32'h6666_6000);
      do_flush_one(32'h0004_2FFF);
      exp_look("R9 kept slot flushed", 1, 32'h0004_2ABC, 0, 0, 0);
      exp_rd("R9 slot5 still valid", 5, 1, 0, 2'd2, 2'd1, 32'h7777_7000, 32'h8888_8000);

      @(negedge clk);
      #3;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule